// File: doc/BRIEF.md
# Serial Line Transceiver with Polarity Control

This block is a single-character asynchronous serial transceiver for a register bus. It provides an 8-bit data register, a 16-bit baud divisor register and a control word that doubles as a status word on read. A character written to the data register is framed as a start bit, eight data bits sent least significant first, an optional parity bit and one stop bit. A character arriving on the receive pin is captured into a one-deep receive buffer that software empties by reading it.

Each direction of the line can be inverted independently, so the port can face either idle-high or idle-low wiring. The transmitter can be forced into a continuous break. The status word reports the buffer states, three sticky error flags with a summary bit, the break request and the raw (synchronised, uninverted) level of the receive pin. A single interrupt request combines a receive-ready condition and a transmit-ready condition, each under its own enable.

Top module: `sp_polar_uart`

## Requirements
- R1: The divisor register sits at address 2, resets to 0 and reads back what was written. One bit period lasts 16 × (divisor + 1) clock cycles.
- R2: Writing address 0 loads the transmit buffer and clears transmit-buffer-empty (status bit 8) on the next cycle. The character goes out as a 0 start bit, data LSB first, a parity bit when parity is enabled (control bit 1), and a 1 stop bit.
- R3: With control bit 0 clear, the parity bit makes the count of ones over data plus parity even. With control bit 0 set, that count is odd.
- R4: A received character appears on reads of address 0 and sets receive-buffer-full (status bit 7). A read of address 0 with the read strobe clears that bit.
- R5: When parity is enabled and the received parity bit is wrong, the parity error flag (status bit 9) is set.
- R6: When the stop bit is sampled as 0, the framing error flag (status bit 10) is set.
- R7: When a character completes while the receive buffer is still full, the overrun flag (status bit 11) is set. The new character is discarded and the buffered one is kept.
- R8: Status bit 15 is the OR of the parity, framing and overrun flags.
- R9: Writing the control word (address 1) with bit 6 set clears all three error flags. Bit 6 is not stored.
- R10: Control bit 2 inverts the transmit pin. Control bit 3 inverts the receive pin before it is decoded.
- R11: While control bit 14 is set, the transmit pin is held at the space level, 0 XOR the transmit-invert bit, and status bit 14 reads 1.
- R12: Status bits 4..0 mirror control bits 4..0. Status bit 13 is the raw receive pin level. Status bits 12, 6 and 5 read 0.
- R13: irq = (control bit 5 AND receive-buffer-full) OR (control bit 4 AND transmit-buffer-empty).
- R14: After reset, the status word reads 0x2100 with the receive pin high, the transmit pin is 1 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control/status, 2 divisor |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; empties the receive buffer when bus_addr is 0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| rx_pin | input | 1 | Serial receive line |
| tx_pin | output | 1 | Serial transmit line (registered) |
| irq | output | 1 | Interrupt request |

## Verification
Characters are sent through the receiver and the transmitter under every combination of parity off, even parity and odd parity, and under each polarity setting. Data patterns with even and odd counts of ones are included, so a swapped parity sense and a bit-order reversal each show up as a wrong value. Directed frames with a corrupted parity bit, a zero stop bit and two characters sent back to back each raise exactly one error flag, which separates the three error detectors and proves that the clear strobe resets them. The width of a single data bit on the transmit pin is measured to confirm the divisor arithmetic. The break and interrupt tests are run with both levels of the transmit-invert bit and with each interrupt enable set on its own.

// File: rtl/sp_polar_pkg.sv
package sp_polar_pkg;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 16;
    localparam int REG_W  = 16;
    localparam int OVS    = 16;
    localparam int OVS_W  = $clog2(OVS);
    localparam int HALF   = OVS / 2;
    localparam int BIT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_DIV  = 2'd2
    } sp_addr_e;

    // Control bit positions
    localparam int C_ODD   = 0;
    localparam int C_PAREN = 1;
    localparam int C_TXINV = 2;
    localparam int C_RXINV = 3;
    localparam int C_TXIE  = 4;
    localparam int C_RXIE  = 5;
    localparam int C_CLR   = 6;
    localparam int C_BRK   = 14;

    // Status bit positions
    localparam int S_RBF  = 7;
    localparam int S_TBE  = 8;
    localparam int S_PE   = 9;
    localparam int S_FE   = 10;
    localparam int S_OE   = 11;
    localparam int S_PIN  = 13;
    localparam int S_BRK  = 14;
    localparam int S_ERR  = 15;

    typedef struct packed {
        logic brk;
        logic rx_ie;
        logic tx_ie;
        logic rx_inv;
        logic tx_inv;
        logic par_en;
        logic par_odd;
    } sp_ctrl_t;

    typedef struct packed {
        logic pe;
        logic fe;
        logic oe;
    } sp_err_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } sp_rx_state_e;

    // Parity bit for a character: even sense makes total ones even.
    function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction
endpackage

// File: rtl/sp_baud_gen.sv
module sp_baud_gen
    import sp_polar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= divisor) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_polar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              tbe,
    output logic              line
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int IDX_W   = $clog2(FRAME_W + 1);

    logic [DATA_W-1:0]  hold;
    logic [FRAME_W-1:0] shreg;
    logic [IDX_W-1:0]   nbits;
    logic [IDX_W-1:0]   bit_idx;
    logic [OVS_W-1:0]   tick_cnt;
    logic               busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= '0;
            shreg    <= '1;
            nbits    <= '0;
            bit_idx  <= '0;
            tick_cnt <= '0;
            busy     <= 1'b0;
            tbe      <= 1'b1;
        end else begin
            if (load) begin
                hold <= wdata;
                tbe  <= 1'b0;
            end else if (!busy && !tbe) begin
                shreg    <= {1'b1, (par_en ? par_bit(hold, par_odd) : 1'b1), hold, 1'b0};
                nbits    <= par_en ? IDX_W'(FRAME_W) : IDX_W'(FRAME_W - 1);
                bit_idx  <= '0;
                tick_cnt <= '0;
                busy     <= 1'b1;
                tbe      <= 1'b1;
            end
            if (busy && tick) begin
                tick_cnt <= tick_cnt + 1'b1;
                if (tick_cnt == OVS_W'(OVS - 1)) begin
                    shreg   <= {1'b1, shreg[FRAME_W-1:1]};
                    bit_idx <= bit_idx + 1'b1;
                    if (bit_idx == nbits - 1'b1) busy <= 1'b0;
                end
            end
        end
    end

    assign line = busy ? shreg[0] : 1'b1;

    // R2: a write to the data register leaves the buffer occupied next cycle
    a_r2_write_clears_tbe: assert property (@(posedge clk) disable iff (rst)
        load |=> !tbe);
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_polar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rx,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rd_clr,
    input  logic              err_clr,
    output logic [DATA_W-1:0] data,
    output logic              rbf,
    output sp_err_t           err
);
    sp_rx_state_e      state;
    logic [OVS_W-1:0]  tick_cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] sh;
    logic              pbit;
    logic              last_tick;
    logic              done;

    assign last_tick = tick && (tick_cnt == OVS_W'(OVS - 1));
    assign done      = (state == RX_STOP) && last_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            tick_cnt <= '0;
            bit_idx  <= '0;
            sh       <= '0;
            pbit     <= 1'b0;
            data     <= '0;
            rbf      <= 1'b0;
            err      <= '0;
        end else begin
            if (rd_clr) rbf <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        if (!rx) begin
                            state    <= RX_START;
                            tick_cnt <= '0;
                        end
                    end
                    RX_START: begin
                        tick_cnt <= tick_cnt + 1'b1;
                        if (tick_cnt == OVS_W'(HALF - 1)) begin
                            tick_cnt <= '0;
                            bit_idx  <= '0;
                            state    <= rx ? RX_IDLE : RX_DATA;
                        end
                    end
                    RX_DATA: begin
                        tick_cnt <= tick_cnt + 1'b1;
                        if (last_tick) begin
                            sh      <= {rx, sh[DATA_W-1:1]};
                            bit_idx <= bit_idx + 1'b1;
                            if (bit_idx == BIT_W'(DATA_W - 1))
                                state <= par_en ? RX_PAR : RX_STOP;
                        end
                    end
                    RX_PAR: begin
                        tick_cnt <= tick_cnt + 1'b1;
                        if (last_tick) begin
                            pbit  <= rx;
                            state <= RX_STOP;
                        end
                    end
                    RX_STOP: begin
                        tick_cnt <= tick_cnt + 1'b1;
                        if (last_tick) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
            if (done) begin
                if (rbf && !rd_clr) begin
                    err.oe <= 1'b1;
                end else begin
                    data   <= sh;
                    rbf    <= 1'b1;
                    err.pe <= err.pe | (par_en && (pbit != par_bit(sh, par_odd)));
                    err.fe <= err.fe | !rx;
                end
            end
            if (err_clr) err <= '0;
        end
    end

    // R7: a character finishing into a full buffer is dropped
    a_r7_overrun_keeps_data: assert property (@(posedge clk) disable iff (rst)
        (done && rbf && !rd_clr) |=> (rbf && $stable(data)));

    // R4: reading the data register empties the buffer
    a_r4_read_empties: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !done) |=> !rbf);
endmodule

// File: rtl/sp_polar_uart.sv
module sp_polar_uart
    import sp_polar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             rx_pin,
    output logic             tx_pin,
    output logic             irq
);
    sp_ctrl_t          ctrl;
    logic [DIV_W-1:0]  divisor;
    logic [1:0]        rx_sync;
    logic              tick;
    logic              tx_line;
    logic              tbe;
    logic              rbf;
    logic [DATA_W-1:0] rx_data;
    sp_err_t           err;
    logic              wr_data, wr_ctrl, err_clr, rd_data;
    logic [REG_W-1:0]  status;

    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign err_clr = wr_ctrl && bus_wdata[C_CLR];
    assign rd_data = bus_rd && (bus_addr == ADDR_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            divisor <= '0;
            rx_sync <= 2'b11;
            tx_pin  <= 1'b1;
        end else begin
            rx_sync <= {rx_sync[0], rx_pin};
            if (wr_ctrl) begin
                ctrl.brk     <= bus_wdata[C_BRK];
                ctrl.rx_ie   <= bus_wdata[C_RXIE];
                ctrl.tx_ie   <= bus_wdata[C_TXIE];
                ctrl.rx_inv  <= bus_wdata[C_RXINV];
                ctrl.tx_inv  <= bus_wdata[C_TXINV];
                ctrl.par_en  <= bus_wdata[C_PAREN];
                ctrl.par_odd <= bus_wdata[C_ODD];
            end
            if (bus_wr && (bus_addr == ADDR_DIV)) divisor <= bus_wdata[DIV_W-1:0];
            tx_pin <= (ctrl.brk ? 1'b0 : tx_line) ^ ctrl.tx_inv;
        end
    end

    sp_baud_gen u_baud (
        .clk     (clk),
        .rst     (rst),
        .divisor (divisor),
        .tick    (tick)
    );

    sp_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (wr_data),
        .wdata   (bus_wdata[DATA_W-1:0]),
        .par_en  (ctrl.par_en),
        .par_odd (ctrl.par_odd),
        .tbe     (tbe),
        .line    (tx_line)
    );

    sp_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .rx      (rx_sync[1] ^ ctrl.rx_inv),
        .par_en  (ctrl.par_en),
        .par_odd (ctrl.par_odd),
        .rd_clr  (rd_data),
        .err_clr (err_clr),
        .data    (rx_data),
        .rbf     (rbf),
        .err     (err)
    );

    always_comb begin
        status         = '0;
        status[C_ODD]   = ctrl.par_odd;
        status[C_PAREN] = ctrl.par_en;
        status[C_TXINV] = ctrl.tx_inv;
        status[C_RXINV] = ctrl.rx_inv;
        status[C_TXIE]  = ctrl.tx_ie;
        status[S_RBF]   = rbf;
        status[S_TBE]   = tbe;
        status[S_PE]    = err.pe;
        status[S_FE]    = err.fe;
        status[S_OE]    = err.oe;
        status[S_PIN]   = rx_sync[1];
        status[S_BRK]   = ctrl.brk;
        status[S_ERR]   = err.pe | err.fe | err.oe;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = REG_W'(rx_data);
            ADDR_CTRL: bus_rdata = status;
            ADDR_DIV:  bus_rdata = REG_W'(divisor);
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = (ctrl.rx_ie && rbf) || (ctrl.tx_ie && tbe);

    // R9: the clear strobe leaves no error flag set on the next cycle
    a_r9_clear_errors: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> (status[S_ERR:S_PE] == 7'b0000000 || !status[S_ERR]) && !status[S_PE] && !status[S_FE] && !status[S_OE]);

    // R11: a held break drives the space level after inversion
    a_r11_break_level: assert property (@(posedge clk) disable iff (rst)
        ctrl.brk |=> (tx_pin == $past(ctrl.tx_inv)));
endmodule

// File: tb/sp_polar_uart_bench.sv
module sp_polar_uart_bench;
    localparam int DIV = 1;
    localparam int T   = 16 * (DIV + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        rx_pin = 1'b1;
    logic        tx_pin;
    logic        irq;

    int nchecks = 0;
    int nerr = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sp_polar_uart u_sp_polar_uart (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_pin(rx_pin), .tx_pin(tx_pin), .irq(irq)
    );

    // {rx_inv, tx_inv, par_en, par_odd, data[7:0]}
    localparam logic [11:0] VEC [8] = '{
        12'h0_55, 12'h2_A5, 12'h3_3C, 12'h4_F0,
        12'h8_0F, 12'hE_81, 12'hF_00, 12'h2_FE
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic pop(output logic [15:0] v);
        @(negedge clk);
        bus_addr = 2'd0; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_bit(input logic lvl, input logic inv);
        rx_pin = lvl ^ inv;
        repeat (T) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] d, input logic pen, input logic odd,
                           input logic bad_par, input logic bad_stop, input logic inv);
        send_bit(1'b0, inv);
        for (int i = 0; i < 8; i++) send_bit(d[i], inv);
        if (pen) send_bit(((^d) ^ odd) ^ bad_par, inv);
        send_bit(!bad_stop, inv);
        rx_pin = 1'b1 ^ inv;
        repeat (T) @(negedge clk);
    endtask

    task automatic get_tx(input logic inv, input logic pen, output logic [7:0] d,
                          output logic p, output logic s);
        int guard = 0;
        @(negedge clk);
        while (tx_pin !== inv && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (T / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (T) @(negedge clk);
            d[i] = tx_pin ^ inv;
        end
        p = 1'b0;
        if (pen) begin
            repeat (T) @(negedge clk);
            p = tx_pin ^ inv;
        end
        repeat (T) @(negedge clk);
        s = tx_pin ^ inv;
        repeat (T) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchecks++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  d;
        logic        p, s;
        int          cnt;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R14 reset state
        rd(2'd1, v);
        chk("R14 reset status", v, 16'h2100);
        chk("R14 reset tx_pin", {15'h0, tx_pin}, 16'h0001);
        chk("R14 reset irq", {15'h0, irq}, 16'h0000);
        rd(2'd2, v);
        chk("R1 divisor reset", v, 16'h0000);

        wr(2'd2, 16'(DIV));
        rd(2'd2, v);
        chk("R1 divisor readback", v, 16'(DIV));

        // Vector table walk: R2 R3 R4 R10
        foreach (VEC[k]) begin
            logic rxi, txi, pen, odd;
            logic [7:0] b;
            {rxi, txi, pen, odd} = VEC[k][11:8];
            b = VEC[k][7:0];
            wr(2'd1, {12'h0, VEC[k][11:8]});
            rx_pin = 1'b1 ^ rxi;
            repeat (2 * T) @(negedge clk);
            send_rx(b, pen, odd, 1'b0, 1'b0, rxi);
            rd(2'd1, v);
            chk($sformatf("R4 vec%0d rbf and no errors", k), v & 16'h8E80, 16'h0080);
            pop(v);
            chk($sformatf("R4 R10 vec%0d rx data", k), v, {8'h0, b});
            rd(2'd1, v);
            chk($sformatf("R4 vec%0d rbf cleared", k), {15'h0, v[7]}, 16'h0000);
            wr(2'd0, {8'h0, b});
            get_tx(txi, pen, d, p, s);
            chk($sformatf("R2 R10 vec%0d tx data", k), {8'h0, d}, {8'h0, b});
            chk($sformatf("R2 vec%0d tx stop", k), {15'h0, s}, 16'h0001);
            if (pen)
                chk($sformatf("R3 vec%0d tx parity", k), {15'h0, p}, {15'h0, (^b) ^ odd});
        end

        // R1 bit period: width of a single 1 data bit
        wr(2'd1, 16'h0000);
        rx_pin = 1'b1;
        repeat (2 * T) @(negedge clk);
        wr(2'd0, 16'h0001);
        cnt = 0;
        while (tx_pin !== 1'b0 && cnt < 4000) begin @(negedge clk); cnt++; end
        cnt = 0;
        while (tx_pin !== 1'b1 && cnt < 4000) begin @(negedge clk); cnt++; end
        cnt = 0;
        while (tx_pin === 1'b1 && cnt < 4000) begin @(negedge clk); cnt++; end
        chk("R1 bit period clocks", 16'(cnt), 16'(T));
        repeat (12 * T) @(negedge clk);

        // R5 parity error, R8 summary
        wr(2'd1, 16'h0002);
        send_rx(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        rd(2'd1, v);
        chk("R5 R8 parity error flags", v & 16'h8E00, 16'h8200);
        // R9 clear strobe
        wr(2'd1, 16'h0042);
        rd(2'd1, v);
        chk("R9 errors cleared", v & 16'h8E00, 16'h0000);
        chk("R9 control kept, strobe not stored", v & 16'h007F, 16'h0002);
        pop(v);

        // R6 framing error
        wr(2'd1, 16'h0000);
        send_rx(8'h33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        rd(2'd1, v);
        chk("R6 R8 framing error flags", v & 16'h8E00, 16'h8400);
        pop(v);
        wr(2'd1, 16'h0040);

        // R7 overrun
        send_rx(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_rx(8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(2'd1, v);
        chk("R7 R8 overrun flags", v & 16'h8E80, 16'h8880);
        pop(v);
        chk("R7 first character kept", v, 16'h0011);
        wr(2'd1, 16'h0040);

        // R11 break, both polarities
        wr(2'd1, 16'h4000);
        repeat (3) @(negedge clk);
        chk("R11 break pin plain", {15'h0, tx_pin}, 16'h0000);
        rd(2'd1, v);
        chk("R11 break status", {15'h0, v[14]}, 16'h0001);
        wr(2'd1, 16'h4004);
        repeat (3) @(negedge clk);
        chk("R11 break pin inverted", {15'h0, tx_pin}, 16'h0001);
        wr(2'd1, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R11 break released", {15'h0, tx_pin}, 16'h0001);

        // R13 interrupt request
        wr(2'd1, 16'h0010);
        #1 chk("R13 tx enable with empty buffer", {15'h0, irq}, 16'h0001);
        wr(2'd1, 16'h0020);
        #1 chk("R13 rx enable with empty rx buffer", {15'h0, irq}, 16'h0000);
        send_rx(8'h7E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        #1 chk("R13 rx enable with full buffer", {15'h0, irq}, 16'h0001);
        pop(v);
        #1 chk("R13 irq drops after read", {15'h0, irq}, 16'h0000);

        // R12 status mirror and raw pin level
        rx_pin = 1'b0;
        wr(2'd1, 16'h003F);
        repeat (4) @(negedge clk);
        rd(2'd1, v);
        chk("R12 mirror bits and pin low", v & 16'h30FF, 16'h011F & 16'h30FF);
        wr(2'd1, 16'h0000);
        rx_pin = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd1, v);
        chk("R12 pin high reflected", {15'h0, v[13]}, 16'h0001);

        finish_run();
    end
endmodule